// File: doc/BRIEF.md
# Flash Program/Erase Status and Write-Protect Unit

This block models the internal write machinery of a small flash array. A start pulse for a byte program, a block erase or a full-array erase launches an internal operation. The operation then runs for a fixed number of clock cycles set by a parameter. Byte program clears bits only: the new byte is the old byte ANDed with the supplied data. An erase writes FFh to every byte of its range, one address per cycle. The array is divided into eight equal blocks, selected by the top three address bits. Block 7 (address bits `111`) is the top block.

Two active-low protect inputs guard the array. Each one covers a different set of blocks, and they act independently of each other. An operation aimed at a protected region is dropped and reported by a one-cycle reject pulse. Reads run in parallel with an operation. While the unit is busy, the upper two bits of each read carry status instead of array data. The top bit gives a polling value that depends on the kind of operation. The next bit flips on every read. A device reset input aborts a running operation after a fixed latency.

Top module: `pes_unit`

## Requirements
- R1: After `rst`, `busy` is 0, `rdy_bsy_n` is 1 and `reject` is 0. `rdy_bsy_n` is the inverse of `busy` on every cycle.
- R2: An accepted program raises `busy` at the accepting clock edge. `busy` stays high for exactly PROG_CYC cycles. Afterwards the target byte holds (old byte AND `op_data`).
- R3: A read is issued with `rd_en` at a clock edge, and `rd_data` shows the result from that edge on. During a program, bit 7 of a read equals the inverse of `op_data[7]`. After completion the read returns the true byte.
- R4: A block erase keeps `busy` high for BERASE_CYC cycles. It sets every byte whose top three address bits match the target to FFh and leaves other blocks unchanged. Bit 7 of a read during the erase is 0; after completion it is 1.
- R5: A chip erase keeps `busy` high for CERASE_CYC cycles and sets every byte of the array to FFh.
- R6: The first read after an operation is accepted returns bit 6 = 0. Each further read while busy inverts bit 6. Once the unit is idle, bit 6 is true array data.
- R7: With `top_lock_n` low, a program or block erase into block 7 is dropped. `busy` stays 0, `reject` is high for one cycle, and the array is unchanged. Operations on blocks 0 to 6 are still accepted.
- R8: With `rest_lock_n` low, a program or block erase into blocks 0 to 6 is rejected, while block 7 stays writable. A chip erase is rejected if either protect input is low.
- R9: A start pulse while `busy` is high is ignored. It produces no reject and no array change, and does not change the running operation's length.
- R10: `dev_reset` high at a clock edge while an operation runs aborts it. `busy` then stays high for ABORT_CYC more cycles. An aborted program leaves its byte unchanged. `dev_reset` has no effect while idle.
- R11: When several start pulses coincide, only one operation is launched. Chip erase wins over block erase, and block erase wins over program.
- R12: `rd_data` holds its value on cycles without `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_prog | input | 1 | Byte program start pulse |
| start_berase | input | 1 | Block erase start pulse |
| start_cerase | input | 1 | Full-array erase start pulse |
| op_addr | input | ADDR_W | Target address; the top 3 bits select the block |
| op_data | input | DATA_W | Byte to program |
| top_lock_n | input | 1 | Low protects block 7 |
| rest_lock_n | input | 1 | Low protects blocks 0 to 6 |
| dev_reset | input | 1 | Aborts a running operation |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Read data, with status bits while busy |
| busy | output | 1 | Internal operation active |
| rdy_bsy_n | output | 1 | Low exactly while busy |
| reject | output | 1 | One-cycle pulse for a protected request |

## Verification
The bench builds the unit with the following parameters:
- ADDR_W = 8, giving 256 bytes in blocks of 32.
- PROG_CYC = 12 and BERASE_CYC = 40.
- CERASE_CYC = 300 and ABORT_CYC = 5.

With these values a full-array erase, dozens of random programs with status reads inside the busy window, and a whole-block sweep all complete in a few thousand cycles. BERASE_CYC is only slightly above the 32-byte block size, so the erase sweep must finish just before `busy` falls. An abort four cycles into a 12-cycle program leaves room to check the abort latency exactly.

// File: rtl/pes_pkg.sv
package pes_pkg;
  typedef enum logic [1:0] {OP_NONE, OP_PROG, OP_BERASE, OP_CERASE} op_e;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_ABORT} st_e;
endpackage

// File: rtl/pes_array.sv
module pes_array #(
  parameter int AW = 9,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          a_en,
  input  logic [AW-1:0] a_addr,
  output logic [DW-1:0] a_q,
  input  logic [AW-1:0] b_addr,
  input  logic          b_we,
  input  logic [DW-1:0] b_wd,
  output logic [DW-1:0] b_q
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [0:DEPTH-1];

  // port A: read only, enabled
  always_ff @(posedge clk) begin
    if (a_en) a_q <= mem[a_addr];
  end

  // port B: read-first read/write
  always_ff @(posedge clk) begin
    if (b_we) mem[b_addr] <= b_wd;
    b_q <= mem[b_addr];
  end
endmodule

// File: rtl/pes_guard.sv
module pes_guard
  import pes_pkg::*;
#(
  parameter int AW       = 9,
  parameter int BLK_BITS = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          idle,
  input  logic          start_prog,
  input  logic          start_berase,
  input  logic          start_cerase,
  input  logic [AW-1:0] op_addr,
  input  logic          top_lock_n,
  input  logic          rest_lock_n,
  output op_e           acc_op,
  output logic          reject
);
  op_e  req_op;
  logic is_top;
  logic prot;

  assign is_top = &op_addr[AW-1 -: BLK_BITS];

  always_comb begin
    if (start_cerase)      req_op = OP_CERASE;
    else if (start_berase) req_op = OP_BERASE;
    else if (start_prog)   req_op = OP_PROG;
    else                   req_op = OP_NONE;
  end

  always_comb begin
    case (req_op)
      OP_PROG, OP_BERASE: prot = is_top ? !top_lock_n : !rest_lock_n;
      OP_CERASE:          prot = !top_lock_n || !rest_lock_n;
      default:            prot = 1'b0;
    endcase
  end

  assign acc_op = (idle && !prot) ? req_op : OP_NONE;

  always_ff @(posedge clk) begin
    if (rst) reject <= 1'b0;
    else     reject <= idle && (req_op != OP_NONE) && prot;
  end

  // R7: nothing aimed at the top block launches while it is locked
  a_r7_top_guard: assert property (@(posedge clk) disable iff (rst)
    (((acc_op == OP_PROG) || (acc_op == OP_BERASE)) && is_top) |-> top_lock_n);
  // R8: full-array erase only launches with both regions open
  a_r8_chip_guard: assert property (@(posedge clk) disable iff (rst)
    (acc_op == OP_CERASE) |-> (top_lock_n && rest_lock_n));
endmodule

// File: rtl/pes_engine.sv
module pes_engine
  import pes_pkg::*;
#(
  parameter int AW         = 9,
  parameter int DW         = 8,
  parameter int BLK_BITS   = 3,
  parameter int PROG_CYC   = 20,
  parameter int BERASE_CYC = 80,
  parameter int CERASE_CYC = 600,
  parameter int ABORT_CYC  = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  op_e           acc_op,
  input  logic [AW-1:0] op_addr,
  input  logic [DW-1:0] op_data,
  input  logic          dev_reset,
  input  logic [DW-1:0] b_q,
  output logic          idle,
  output logic          busy,
  output logic          rdy_bsy_n,
  output op_e           cur_op,
  output logic [DW-1:0] cur_data,
  output logic [AW-1:0] b_addr,
  output logic          b_we,
  output logic [DW-1:0] b_wd
);
  localparam int DEPTH     = 1 << AW;
  localparam int BLK_BYTES = 1 << (AW - BLK_BITS);
  localparam int P_LEN  = (PROG_CYC < 2) ? 2 : PROG_CYC;
  localparam int BE_LEN = (BERASE_CYC < BLK_BYTES) ? BLK_BYTES : BERASE_CYC;
  localparam int CE_LEN = (CERASE_CYC < DEPTH) ? DEPTH : CERASE_CYC;
  localparam int AB_LEN = (ABORT_CYC < 1) ? 1 : ABORT_CYC;
  localparam int M1   = (P_LEN > BE_LEN) ? P_LEN : BE_LEN;
  localparam int M2   = (CE_LEN > AB_LEN) ? CE_LEN : AB_LEN;
  localparam int MAXL = (M1 > M2) ? M1 : M2;
  localparam int CW   = $clog2(MAXL + 1);
  localparam logic [AW:0] BLK_CNT = (AW+1)'(BLK_BYTES);
  localparam logic [AW:0] ALL_CNT = (AW+1)'(DEPTH);

  st_e           state;
  logic [CW-1:0] cnt;
  logic [AW-1:0] cur_addr;
  logic [AW-1:0] sw_ptr;
  logic [AW:0]   sw_left;
  logic          sweeping;

  assign idle     = (state == ST_IDLE);
  assign sweeping = (state == ST_RUN) && (sw_left != '0);

  always_comb begin
    b_addr = sweeping ? sw_ptr : cur_addr;
    b_wd   = sweeping ? {DW{1'b1}} : (b_q & cur_data);
    b_we   = (state == ST_RUN) && !dev_reset &&
             (sweeping || ((cur_op == OP_PROG) && (cnt == '0)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      busy      <= 1'b0;
      rdy_bsy_n <= 1'b1;
      cur_op    <= OP_NONE;
      cur_addr  <= '0;
      cur_data  <= '0;
      sw_ptr    <= '0;
      sw_left   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (acc_op != OP_NONE) begin
            state     <= ST_RUN;
            busy      <= 1'b1;
            rdy_bsy_n <= 1'b0;
            cur_op    <= acc_op;
            cur_addr  <= op_addr;
            cur_data  <= op_data;
            case (acc_op)
              OP_BERASE: begin
                cnt     <= CW'(BE_LEN - 1);
                sw_ptr  <= {op_addr[AW-1 -: BLK_BITS], {(AW-BLK_BITS){1'b0}}};
                sw_left <= BLK_CNT;
              end
              OP_CERASE: begin
                cnt     <= CW'(CE_LEN - 1);
                sw_ptr  <= '0;
                sw_left <= ALL_CNT;
              end
              default: begin
                cnt     <= CW'(P_LEN - 1);
                sw_left <= '0;
              end
            endcase
          end
        end
        ST_RUN: begin
          if (sweeping) begin
            sw_ptr  <= sw_ptr + 1'b1;
            sw_left <= sw_left - 1'b1;
          end
          if (dev_reset) begin
            state   <= ST_ABORT;
            cnt     <= CW'(AB_LEN - 1);
            sw_left <= '0;
          end else if (cnt == '0) begin
            state     <= ST_IDLE;
            busy      <= 1'b0;
            rdy_bsy_n <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          if (cnt == '0) begin
            state     <= ST_IDLE;
            busy      <= 1'b0;
            rdy_bsy_n <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
      endcase
    end
  end

  // R1: ready/busy is the exact inverse of busy
  a_r1_rdy_vs_busy: assert property (@(posedge clk) disable iff (rst)
    rdy_bsy_n != busy);
  // R9: a running operation cannot end early without abort
  a_r9_busy_holds: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && !dev_reset && cnt != '0) |=> busy);
  // R10: abort latency keeps the unit busy
  a_r10_abort_holds: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ABORT && cnt != '0) |=> (state == ST_ABORT && busy));
  // R4: an erase sweep completes before the operation ends
  a_r4_sweep_done: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && cnt == '0) |-> (sw_left == '0));
endmodule

// File: rtl/pes_readout.sv
module pes_readout
  import pes_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic          busy,
  input  logic          start_evt,
  input  op_e           cur_op,
  input  logic [DW-1:0] cur_data,
  input  logic [DW-1:0] a_q,
  output logic [DW-1:0] rd_data
);
  logic tog;
  logic st_sel;
  logic st7;
  logic st6;

  always_ff @(posedge clk) begin
    if (rst) begin
      tog    <= 1'b0;
      st_sel <= 1'b0;
      st7    <= 1'b0;
      st6    <= 1'b0;
    end else begin
      if (start_evt)          tog <= 1'b0;
      else if (rd_en && busy) tog <= ~tog;
      if (rd_en) begin
        st_sel <= busy;
        st7    <= (cur_op == OP_PROG) ? ~cur_data[DW-1] : 1'b0;
        st6    <= tog;
      end
    end
  end

  assign rd_data = st_sel ? {st7, st6, a_q[DW-3:0]} : a_q;

  // R12: status selection only moves on a read
  a_r12_sel_stable: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(st_sel));
endmodule

// File: rtl/pes_unit.sv
module pes_unit
  import pes_pkg::*;
#(
  parameter int ADDR_W     = 9,
  parameter int DATA_W     = 8,
  parameter int BLK_BITS   = 3,
  parameter int PROG_CYC   = 20,
  parameter int BERASE_CYC = 80,
  parameter int CERASE_CYC = 600,
  parameter int ABORT_CYC  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_prog,
  input  logic              start_berase,
  input  logic              start_cerase,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [DATA_W-1:0] op_data,
  input  logic              top_lock_n,
  input  logic              rest_lock_n,
  input  logic              dev_reset,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              rdy_bsy_n,
  output logic              reject
);
  op_e               acc_op;
  op_e               cur_op;
  logic              idle;
  logic [DATA_W-1:0] cur_data;
  logic [DATA_W-1:0] a_q, b_q, b_wd;
  logic [ADDR_W-1:0] b_addr;
  logic              b_we;

  pes_guard #(.AW(ADDR_W), .BLK_BITS(BLK_BITS)) u_guard (
    .clk(clk), .rst(rst), .idle(idle),
    .start_prog(start_prog), .start_berase(start_berase),
    .start_cerase(start_cerase), .op_addr(op_addr),
    .top_lock_n(top_lock_n), .rest_lock_n(rest_lock_n),
    .acc_op(acc_op), .reject(reject)
  );

  pes_engine #(
    .AW(ADDR_W), .DW(DATA_W), .BLK_BITS(BLK_BITS), .PROG_CYC(PROG_CYC),
    .BERASE_CYC(BERASE_CYC), .CERASE_CYC(CERASE_CYC), .ABORT_CYC(ABORT_CYC)
  ) u_engine (
    .clk(clk), .rst(rst), .acc_op(acc_op), .op_addr(op_addr),
    .op_data(op_data), .dev_reset(dev_reset), .b_q(b_q), .idle(idle),
    .busy(busy), .rdy_bsy_n(rdy_bsy_n), .cur_op(cur_op),
    .cur_data(cur_data), .b_addr(b_addr), .b_we(b_we), .b_wd(b_wd)
  );

  pes_array #(.AW(ADDR_W), .DW(DATA_W)) u_array (
    .clk(clk), .a_en(rd_en), .a_addr(rd_addr), .a_q(a_q),
    .b_addr(b_addr), .b_we(b_we), .b_wd(b_wd), .b_q(b_q)
  );

  pes_readout #(.DW(DATA_W)) u_readout (
    .clk(clk), .rst(rst), .rd_en(rd_en), .busy(busy),
    .start_evt(acc_op != OP_NONE), .cur_op(cur_op), .cur_data(cur_data),
    .a_q(a_q), .rd_data(rd_data)
  );

  // R7: a rejected request never starts an operation
  a_r7_reject_idle: assert property (@(posedge clk) disable iff (rst)
    reject |-> !busy);
endmodule

// File: tb/test_pes_unit.sv
module test_pes_unit;
  localparam int AW = 8, BB = 3, PC = 12, BEC = 40, CEC = 300, ABC = 5;
  localparam int DEPTH = 1 << AW;
  localparam int BLKB = 1 << (AW - BB);

  logic clk = 1'b0, rst = 1'b1;
  logic start_prog = 0, start_berase = 0, start_cerase = 0;
  logic [AW-1:0] op_addr = '0, rd_addr = '0;
  logic [7:0] op_data = '0, rd_data;
  logic top_lock_n = 1, rest_lock_n = 1, dev_reset = 0, rd_en = 0;
  logic busy, rdy_bsy_n, reject;

  int checks = 0, fails = 0, busy_cycles = 0;
  logic [7:0] shadow [0:DEPTH-1];

  pes_unit #(.ADDR_W(AW), .DATA_W(8), .BLK_BITS(BB), .PROG_CYC(PC),
             .BERASE_CYC(BEC), .CERASE_CYC(CEC), .ABORT_CYC(ABC)) i_pes_unit (
    .clk(clk), .rst(rst), .start_prog(start_prog), .start_berase(start_berase),
    .start_cerase(start_cerase), .op_addr(op_addr), .op_data(op_data),
    .top_lock_n(top_lock_n), .rest_lock_n(rest_lock_n), .dev_reset(dev_reset),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy),
    .rdy_bsy_n(rdy_bsy_n), .reject(reject));

  always #5 clk = ~clk;
  always @(negedge clk) if (busy) busy_cycles++;

  function automatic logic [1:0] poll_bits(input int kind, input logic [7:0] d, input logic t);
    return {(kind == 1) ? ~d[7] : 1'b0, t};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // kind bits: 1 program, 2 block erase, 4 chip erase
  task automatic do_start(input int kind, input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    busy_cycles = 0;
    op_addr = a; op_data = d;
    start_prog = kind[0]; start_berase = kind[1]; start_cerase = kind[2];
    @(negedge clk);
    start_prog = 0; start_berase = 0; start_cerase = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] q);
    @(negedge clk);
    rd_en = 1; rd_addr = a;
    @(negedge clk);
    rd_en = 0;
    q = rd_data;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] q, q2;
    logic [AW-1:0] a;
    logic [7:0] d;
    int bad;
    void'($urandom(32'd1234));

    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 busy", busy, 0); chk("R1 rdy", rdy_bsy_n, 1); chk("R1 reject", reject, 0);
    rst = 0;

    // R5 chip erase
    do_start(4, 8'h55, 8'h00);
    chk("R1 rdy inverse", rdy_bsy_n, 0);
    wait_idle();
    chk("R5 length", busy_cycles, CEC);
    for (int i = 0; i < DEPTH; i++) shadow[i] = 8'hFF;
    bad = 0;
    for (int i = 0; i < DEPTH; i += 7) begin rd(AW'(i), q); if (q !== 8'hFF) bad++; end
    chk("R5 erased", bad, 0);

    // R2 R3 R6 random programs with status reads
    for (int n = 0; n < 20; n++) begin
      a = AW'($urandom_range(0, DEPTH-1)); d = 8'($urandom);
      do_start(1, a, d);
      rd(a, q);  chk("R3 poll first", q[7:6], poll_bits(1, d, 1'b0));
      rd(a, q2); chk("R6 toggle", q2[7:6], poll_bits(1, d, 1'b1));
      rd(a, q);  chk("R6 toggle back", q[6], 1'b0);
      wait_idle();
      chk("R2 length", busy_cycles, PC);
      shadow[a] = shadow[a] & d;
      rd(a, q); chk("R2 R3 data", q, shadow[a]);
    end

    // R12 hold
    rd(8'h10, q);
    repeat (4) @(negedge clk);
    chk("R12 hold", rd_data, q);

    // R4 block erase
    a = {3'($urandom_range(0, 6)), 5'd3};
    shadow[a] = 8'h3C; do_start(1, a, 8'h3C); wait_idle();
    shadow[a ^ 8'h20] = shadow[a ^ 8'h20] & 8'h0F; do_start(1, a ^ 8'h20, 8'h0F); wait_idle();
    do_start(2, a, 8'h00);
    rd(a, q); chk("R4 poll busy", q[7:6], poll_bits(2, 8'h00, 1'b0));
    wait_idle();
    chk("R4 length", busy_cycles, BEC);
    bad = 0;
    for (int i = 0; i < BLKB; i++) begin
      rd({a[7:5], 5'(i)}, q); if (q !== 8'hFF) bad++;
      shadow[{a[7:5], 5'(i)}] = 8'hFF;
    end
    chk("R4 block FF", bad, 0);
    rd(a ^ 8'h20, q); chk("R4 other block", q, shadow[a ^ 8'h20]);

    // R7 top lock
    top_lock_n = 0;
    do_start(1, 8'hE5, 8'h00);
    chk("R7 reject", reject, 1); chk("R7 no busy", busy, 0);
    @(negedge clk); chk("R7 pulse one", reject, 0);
    rd(8'hE5, q); chk("R7 unchanged", q, shadow[8'hE5]);
    do_start(1, 8'h61, 8'h7E); chk("R7 others open", busy, 1);
    wait_idle(); shadow[8'h61] = shadow[8'h61] & 8'h7E;
    top_lock_n = 1;

    // R8 rest lock
    rest_lock_n = 0;
    do_start(2, 8'h44, 8'h00); chk("R8 reject", reject, 1); chk("R8 no busy", busy, 0);
    rd(8'h61, q); chk("R8 unchanged", q, shadow[8'h61]);
    do_start(4, 8'h00, 8'h00); chk("R8 chip reject", reject, 1);
    do_start(1, 8'hF0, 8'hA5); chk("R8 top open", busy, 1);
    wait_idle(); shadow[8'hF0] = shadow[8'hF0] & 8'hA5;
    rd(8'hF0, q); chk("R8 top data", q, shadow[8'hF0]);
    rest_lock_n = 1;

    // R9 start while busy
    do_start(1, 8'h22, 8'h0F);
    repeat (2) @(negedge clk);
    start_berase = 1; op_addr = 8'h61;
    @(negedge clk); start_berase = 0;
    chk("R9 no reject", reject, 0);
    wait_idle();
    chk("R9 length", busy_cycles, PC);
    shadow[8'h22] = shadow[8'h22] & 8'h0F;
    rd(8'h61, q); chk("R9 untouched", q, shadow[8'h61]);
    rd(8'h22, q); chk("R9 program", q, shadow[8'h22]);

    // R10 abort
    shadow[8'h33] = 8'hFF;
    do_start(1, 8'h33, 8'h00);
    repeat (3) @(negedge clk);
    dev_reset = 1; @(negedge clk); dev_reset = 0;
    wait_idle();
    chk("R10 abort length", busy_cycles, 4 + ABC);
    rd(8'h33, q); chk("R10 aborted unchanged", q, shadow[8'h33]);
    dev_reset = 1; @(negedge clk); dev_reset = 0;
    chk("R10 idle no effect", busy, 0);
    rd(8'h22, q); chk("R10 idle data", q, shadow[8'h22]);

    // R11 priority
    do_start(3, 8'h9A, 8'h00);
    wait_idle();
    chk("R11 erase wins", busy_cycles, BEC);
    rd(8'h9A, q); chk("R11 data", q, 8'hFF);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule